// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width-modulated outputs from a single clock. Each channel counts through two cascaded stages. A prescaler stretches every step of a period counter to several input clocks, and a high-time count, given in those stretched steps, sets how long the output stays high at the start of each period. Output polarity is always active-high.

Software programs each channel through a plain 32-bit register port with two words per channel. Writes land in staging registers that the counters do not see. A write to the second word with its commit bit set hands the staged set to the channel. A running channel switches at the end of its current period. A stopped channel switches on the next clock. Because of this, a pulse is never cut short or stretched while a new setting is being written.

Top module: `pwmgen_top`

## Requirements
- R1: Channel c (0..3) uses byte address 8*c for its first word and 8*c+4 for its second word; address bits [1:0] are ignored. In the first word, bits [15:0] are the period count P and bits [31:16] are the high count H.
- R2: In the second word, bits [15:0] are the prescale count S, bit 31 is the run enable and bit 30 is the commit strobe; the other bits are ignored on write and read as 0.
- R3: A running channel repeats a period of (S+1)*(P+1) clocks. Its output is high for the first H*(S+1) clocks of each period and low for the rest.
- R4: When H is P+1 or greater, the output stays high for the whole period.
- R5: When H is 0, the output stays low for the whole period.
- R6: Writes to either word without the commit bit set do not change the waveform of any channel.
- R7: A commit issued while the channel is stopped is applied on the second clock edge after the bus write. The new period starts from zero, so the output rises at that edge if H is greater than 0.
- R8: A commit issued while the channel is running is held until the current period ends. The new settings then start with a fresh period, and the old period finishes at its full length and high time.
- R9: Reads return the value last written to each field, except that the commit bit always reads as 0.
- R10: While the committed enable is 0, the channel output is low and its counters stay at zero.
- R11: Configuring or committing one channel does not alter the waveform of any other channel.
- R12: After reset, all fields read as zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and registers |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bound checker enforces several properties on every clock cycle:
- the commit bit never reads back as 1;
- a stopped channel never drives its output high;
- a channel arms a pending update only after a commit write to that channel;
- an output rises only where a period starts, which is either a natural wrap or an applied update.

Some behaviours need the bench's scenarios because they depend on exact counts:
- the exact high and low run lengths for each combination of prescale, period and high count;
- the old period finishing intact when a running channel is reprogrammed;
- the one-clock start delay of a stopped channel;
- the fact that staged but uncommitted values leave the waveform untouched.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    localparam int CNT_W  = 16;
    localparam int WORD_W = 32;
    localparam int BIT_COMMIT = 30;
    localparam int BIT_RUN    = 31;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
    } chan_cfg_t;

    function automatic logic [WORD_W-1:0] pack_word0(chan_cfg_t c);
        return {c.high, c.period};
    endfunction

    function automatic logic [WORD_W-1:0] pack_word1(chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CNT_W-1:0] = c.pre;
        w[BIT_RUN]   = c.run;
        return w;
    endfunction
endpackage

// File: rtl/pwmgen_regs.sv
module pwmgen_regs
    import pwmgen_pkg::*;
#(
    parameter int NCH = 4,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW = SEL_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [AW-1:0]           bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output chan_cfg_t [NCH-1:0]     stage_cfg,
    output logic [NCH-1:0]          commit
);
    logic [SEL_W-1:0] sel;
    logic             hi_word;
    logic             wr;

    assign sel     = bus_addr[AW-1:3];
    assign hi_word = bus_addr[2];
    assign wr      = bus_valid && bus_write;

    for (genvar c = 0; c < NCH; c++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_cfg[c] <= '0;
                commit[c]    <= 1'b0;
            end else begin
                commit[c] <= 1'b0;
                if (wr && sel == SEL_W'(c)) begin
                    if (!hi_word) begin
                        stage_cfg[c].high   <= bus_wdata[WORD_W-1:CNT_W];
                        stage_cfg[c].period <= bus_wdata[CNT_W-1:0];
                    end else begin
                        stage_cfg[c].pre <= bus_wdata[CNT_W-1:0];
                        stage_cfg[c].run <= bus_wdata[BIT_RUN];
                        commit[c]        <= bus_wdata[BIT_COMMIT];
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel == SEL_W'(c)) begin
                bus_rdata = hi_word ? pack_word1(stage_cfg[c]) : pack_word0(stage_cfg[c]);
            end
        end
    end
endmodule

// File: rtl/pwmgen_chan.sv
module pwmgen_chan
    import pwmgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t stage,
    input  logic      commit,
    output logic      out,
    output logic      at_last,
    output logic      apply,
    output logic      pend,
    output logic      running
);
    chan_cfg_t        act_q;
    chan_cfg_t        pend_cfg_q;
    logic             pend_q;
    logic [CNT_W-1:0] pre_cnt_q;
    logic [CNT_W-1:0] per_cnt_q;
    logic             pre_wrap;
    logic             now_apply;
    logic             late_apply;

    assign pre_wrap   = (pre_cnt_q == act_q.pre);
    assign at_last    = act_q.run && pre_wrap && (per_cnt_q == act_q.period);
    assign now_apply  = commit && !act_q.run;
    assign late_apply = pend_q && at_last;
    assign apply      = now_apply || late_apply;
    assign pend       = pend_q;
    assign running    = act_q.run;
    assign out        = act_q.run && (per_cnt_q < act_q.high);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= '0;
            pend_cfg_q <= '0;
            pend_q     <= 1'b0;
            pre_cnt_q  <= '0;
            per_cnt_q  <= '0;
        end else begin
            if (commit) begin
                pend_cfg_q <= stage;
            end
            if (now_apply) begin
                act_q     <= stage;
                pend_q    <= 1'b0;
                pre_cnt_q <= '0;
                per_cnt_q <= '0;
            end else if (late_apply) begin
                act_q     <= pend_cfg_q;
                pend_q    <= commit;
                pre_cnt_q <= '0;
                per_cnt_q <= '0;
            end else begin
                pend_q <= pend_q || commit;
                if (!act_q.run) begin
                    pre_cnt_q <= '0;
                    per_cnt_q <= '0;
                end else if (pre_wrap) begin
                    pre_cnt_q <= '0;
                    per_cnt_q <= (per_cnt_q == act_q.period) ? '0 : per_cnt_q + 1'b1;
                end else begin
                    pre_cnt_q <= pre_cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
#(
    parameter int NCH = 4,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW = SEL_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    chan_cfg_t [NCH-1:0] stage_cfg;
    logic [NCH-1:0]      commit;
    logic [NCH-1:0]      chan_last;
    logic [NCH-1:0]      chan_apply;
    logic [NCH-1:0]      chan_pend;
    logic [NCH-1:0]      chan_run;

    pwmgen_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stage_cfg (stage_cfg),
        .commit    (commit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwmgen_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .stage   (stage_cfg[c]),
            .commit  (commit[c]),
            .out     (pwm_out[c]),
            .at_last (chan_last[c]),
            .apply   (chan_apply[c]),
            .pend    (chan_pend[c]),
            .running (chan_run[c])
        );
    end
endmodule

// File: rtl/pwmgen_chk.sv
module pwmgen_chk
    import pwmgen_pkg::*;
#(
    parameter int NCH = 4,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW = SEL_W + 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [AW-1:0]     bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NCH-1:0]    pwm_out,
    input logic [NCH-1:0]    chan_last,
    input logic [NCH-1:0]    chan_apply,
    input logic [NCH-1:0]    chan_pend,
    input logic [NCH-1:0]    chan_run
);
    // R9
    commit_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr[2]) |-> !bus_rdata[BIT_COMMIT]);

    // R12
    out_known_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(pwm_out));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic hit;
        assign hit = bus_valid && bus_write && bus_addr[2] &&
                     (bus_addr[AW-1:3] == SEL_W'(c)) && bus_wdata[BIT_COMMIT];

        // R10
        stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
            !chan_run[c] |-> !pwm_out[c]);

        // R6
        pend_needs_commit_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(chan_pend[c]) |-> $past(hit, 2));

        // R8
        rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_out[c]) |-> $past(chan_last[c] || chan_apply[c]));
    end
endmodule

bind pwmgen_top pwmgen_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pwm_out    (pwm_out),
    .chan_last  (chan_last),
    .chan_apply (chan_apply),
    .chan_pend  (chan_pend),
    .chan_run   (chan_run)
);

// File: tb/pwmgen_top_tb.sv
module pwmgen_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int    ch;
        int    hi;
        int    lo;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    pwmgen_top u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic bus_wr(int addr, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'(addr); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(int addr, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'(addr);
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] w0(int high, int period);
        return {16'(high), 16'(period)};
    endfunction

    function automatic logic [31:0] w1(bit run, bit upd, int pre);
        return {run, upd, 14'h0, 16'(pre)};
    endfunction

    task automatic wait_rise(int ch);
        bit prev;
        prev = pwm_out[ch];
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    // starts at a negedge with the output just risen, ends at the next rise
    task automatic run_lengths(int ch, output int hi, output int lo);
        hi = 0; lo = 0;
        while (pwm_out[ch] && hi < 2000) begin hi++; @(negedge clk); end
        while (!pwm_out[ch] && lo < 2000) begin lo++; @(negedge clk); end
    endtask

    task automatic push_exp(int ch, int hi, int lo, string tag);
        exp_t e;
        e.ch = ch; e.hi = hi; e.lo = lo; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic monitor_pop();
        exp_t e;
        int hi, lo;
        e = sbq.pop_front();
        run_lengths(e.ch, hi, lo);
        check(hi == e.hi, e.tag, $sformatf("ch%0d high run", e.ch), hi, e.hi);
        check(lo == e.lo, e.tag, $sformatf("ch%0d low run", e.ch), lo, e.lo);
    endtask

    task automatic check_const(int ch, bit val, int n, string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch] != val) bad++;
        end
        check(bad == 0, tag, $sformatf("ch%0d cycles off level %0d", ch, val), bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check(pwm_out == 4'h0, "R12", "outputs after reset", pwm_out, 0);
        bus_rd(0, rd);
        check(rd == 32'h0, "R12", "ch0 word0 after reset", rd, 0);
        bus_rd(28, rd);
        check(rd == 32'h0, "R12", "ch3 word1 after reset", rd, 0);

        // R1 R2 R9 readback, commit bit reads 0, unused bits read 0
        bus_wr(8, w0(3, 9));
        bus_rd(8, rd);
        check(rd == w0(3, 9), "R1", "ch1 word0 readback", rd, w0(3, 9));
        bus_rd(9, rd);
        check(rd == w0(3, 9), "R1", "low address bits ignored", rd, w0(3, 9));
        bus_wr(12, 32'h3FFF_0000);
        bus_rd(12, rd);
        check(rd == 32'h0, "R2", "ignored bits of word1", rd, 0);

        // R7 R3: stopped channel, commit applies next clock
        bus_wr(0, w0(2, 4));
        bus_wr(4, w1(1, 1, 1));
        @(negedge clk);
        check(pwm_out[0] == 1'b1, "R7", "ch0 high one clock after commit", pwm_out[0], 1);
        push_exp(0, 4, 6, "R7");
        push_exp(0, 4, 6, "R3");
        monitor_pop();
        monitor_pop();
        bus_rd(4, rd);
        check(rd == w1(1, 0, 1), "R9", "ch0 word1 commit reads 0", rd, w1(1, 0, 1));

        // R3 second pattern, ch1 with no prescale
        bus_wr(12, w1(1, 1, 0));
        @(negedge clk);
        push_exp(1, 3, 7, "R3");
        monitor_pop();

        // R4 full duty and R5 zero duty
        bus_wr(16, w0(3, 2));
        bus_wr(20, w1(1, 1, 2));
        bus_wr(24, w0(0, 5));
        bus_wr(28, w1(1, 1, 0));
        check_const(2, 1'b1, 30, "R4");
        check_const(3, 1'b0, 30, "R5");

        // R6: staged without commit leaves ch1 unchanged
        bus_wr(8, w0(8, 9));
        bus_wr(12, w1(1, 0, 0));
        wait_rise(1);
        push_exp(1, 3, 7, "R6");
        monitor_pop();
        bus_rd(8, rd);
        check(rd == w0(8, 9), "R9", "ch1 staged word0 readback", rd, w0(8, 9));

        // R8: commit mid-period; old period completes, then new
        bus_wr(0, w0(1, 3));
        wait_rise(0);
        push_exp(0, 4, 6, "R8");
        push_exp(0, 1, 3, "R8");
        fork
            begin @(negedge clk); bus_wr(4, w1(1, 1, 0)); end
            monitor_pop();
        join
        monitor_pop();

        // R11: ch1 still on its own old setting, ch2/ch3 unchanged
        wait_rise(1);
        push_exp(1, 3, 7, "R11");
        monitor_pop();
        check_const(2, 1'b1, 10, "R11");
        check_const(3, 1'b0, 10, "R11");

        // R10: stop ch0, output low thereafter
        bus_wr(4, w1(0, 1, 0));
        repeat (10) @(negedge clk);
        check_const(0, 1'b0, 30, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule